// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide, two-offset host interface into an embedded controller. A host CPU writes command bytes and data bytes through two port offsets and polls a status byte. The block tracks when it still holds an unprocessed host byte (input-full flag) and when it holds a result for the host (output-full flag).

Behind the host interface, a small sequencer accepts two commands. One reads a byte from a 256-entry internal register space. The other writes a byte into that space. The register space sits outside the block and is reached through a synchronous register-file port: a write strobe stores data on the clock edge, and a read strobe returns data one cycle later.

Each host byte is consumed a fixed number of cycles after it arrives. That number is set by a parameter from 1 to 8. A host that polls the status byte therefore sees the input-full flag drop long before any polling limit it keeps.

Top module: `ecp_host_port`

## Requirements
- R1: Host offset 0 is the data port and offset 4 is the control port. A read at any other offset returns 0x00. A write at any other offset is ignored and does not set the input-full flag.
- R2: A read of offset 4 returns the status byte. Bit 1 is the input-full flag, bit 0 is the output-full flag, and bits 7..2 are zero.
- R3: A host write to offset 0 or 4 sets the input-full flag on the capturing edge. The flag then stays set for exactly `IBF_LAT` cycles (1 to 8), after which the byte is consumed and the flag clears.
- R4: A write of 0x80 to offset 4, followed by an address byte written to offset 0, reads that internal register. The read value appears at offset 0, and the output-full flag sets one cycle after the address byte is consumed.
- R5: A write of 0x81 to offset 4, followed by an address byte and then a data byte at offset 0, stores the data byte at that address. It does so with a single register-file write strobe, issued in the cycle the data byte is consumed.
- R6: A host read strobe at offset 0 clears the output-full flag on the next edge. The data value held at offset 0 does not change.
- R7: A control-port byte other than 0x80 or 0x81 is consumed and returns the sequencer to idle. Data bytes that follow cause no register-file access.
- R8: A command written while a sequence is in progress abandons that sequence and starts the new one. The abandoned sequence makes no register-file access.
- R9: A data byte written with no command in progress is consumed and ignored. It causes no register-file access and leaves the output-full flag clear.
- R10: After reset, the status byte reads 0x00 and neither register-file strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host port offset (0 data, 4 control/status) |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the current offset |
| rf_addr | output | ADDR_W | Register-file address |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| rf_re | output | 1 | Register-file read strobe |
| rf_rdata | input | 8 | Register-file read data, valid the cycle after `rf_re` |

## Verification
The assertions on flag timing assume that the host follows the handshake. The host never writes while the input-full flag is set. The register file returns data exactly one cycle after a read strobe. The bench keeps within these assumptions in two ways: it polls the status byte until the input-full flag clears before every write, and it polls for the output-full flag before every data-port read. Its register-file model answers read strobes on the next edge. The abort and unknown-command scenarios are also built from handshake-respecting writes only, so they exercise the sequencer rather than the overwrite path.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;

    localparam int unsigned HOST_AW = 3;

    typedef logic [7:0] byte_t;

    localparam logic [HOST_AW-1:0] OFS_DATA = 3'd0;
    localparam logic [HOST_AW-1:0] OFS_CTRL = 3'd4;

    localparam byte_t OP_FETCH = 8'h80;
    localparam byte_t OP_STORE = 8'h81;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_FETCH,
        CK_STORE
    } cmd_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_RD_FETCH,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } seq_state_e;

    // Byte captured from the host, tagged with the port it came through
    typedef struct packed {
        logic  is_cmd;
        byte_t value;
    } in_byte_t;

    typedef struct packed {
        logic ibf;
        logic obf;
    } flags_t;

    function automatic byte_t pack_status(flags_t f);
        return {6'b000000, f.ibf, f.obf};
    endfunction

    function automatic cmd_kind_e decode_cmd(byte_t b);
        if (b == OP_FETCH) return CK_FETCH;
        if (b == OP_STORE) return CK_STORE;
        return CK_NONE;
    endfunction

endpackage

// File: rtl/ecp_host_if.sv
`timescale 1ns/1ps
module ecp_host_if
    import ecp_pkg::*;
#(
    parameter int unsigned IBF_LAT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  byte_t              host_wdata,
    output byte_t              host_rdata,
    output logic               consume,
    output in_byte_t           in_byte,
    input  logic               out_load,
    input  byte_t              out_value
);

    localparam int unsigned CNT_W = $clog2(IBF_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(IBF_LAT - 1);

    flags_t           flags;
    logic [CNT_W-1:0] lat_cnt;
    in_byte_t         in_q;
    byte_t            out_q;
    logic             wr_hit;
    logic             rd_data;

    assign wr_hit  = host_wr && ((host_addr == OFS_DATA) || (host_addr == OFS_CTRL));
    assign rd_data = host_rd && (host_addr == OFS_DATA);
    assign consume = flags.ibf && (lat_cnt == '0);
    assign in_byte = in_q;

    // Input side: capture, hold IBF for the latency, then hand over
    always_ff @(posedge clk) begin
        if (rst) begin
            flags.ibf <= 1'b0;
            lat_cnt   <= '0;
            in_q      <= '0;
        end else if (wr_hit) begin
            flags.ibf <= 1'b1;
            lat_cnt   <= CNT_INIT;
            in_q      <= '{is_cmd: (host_addr == OFS_CTRL), value: host_wdata};
        end else if (consume) begin
            flags.ibf <= 1'b0;
        end else if (flags.ibf) begin
            lat_cnt   <= lat_cnt - 1'b1;
        end
    end

    // Output side: a fresh result beats a simultaneous host read
    always_ff @(posedge clk) begin
        if (rst) begin
            flags.obf <= 1'b0;
            out_q     <= '0;
        end else if (out_load) begin
            flags.obf <= 1'b1;
            out_q     <= out_value;
        end else if (rd_data) begin
            flags.obf <= 1'b0;
        end
    end

    always_comb begin
        case (host_addr)
            OFS_DATA: host_rdata = out_q;
            OFS_CTRL: host_rdata = pack_status(flags);
            default:  host_rdata = '0;
        endcase
    end

    // Checker state: cycles since the last accepted write while IBF stays high
    logic [CNT_W:0] ibf_run;
    localparam logic [CNT_W:0] RUN_MAX = (CNT_W + 1)'(IBF_LAT);

    always_ff @(posedge clk) begin
        if (rst)             ibf_run <= '0;
        else if (wr_hit)     ibf_run <= (CNT_W + 1)'(1);
        else if (flags.ibf && !consume) ibf_run <= ibf_run + 1'b1;
        else                 ibf_run <= '0;
    end

    assert_write_sets_ibf_R3: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> flags.ibf);

    assert_ibf_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        flags.ibf |-> (ibf_run <= RUN_MAX));

    assert_consume_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (flags.ibf && ibf_run == RUN_MAX && !wr_hit) |=> !flags.ibf);

    assert_rd_clears_obf_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_data && flags.obf && !out_load) |=> (!flags.obf && $stable(out_q)));

    assert_ignored_offset_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !wr_hit && !flags.ibf) |=> !flags.ibf);

endmodule

// File: rtl/ecp_sequencer.sv
`timescale 1ns/1ps
module ecp_sequencer
    import ecp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              consume,
    input  in_byte_t          in_byte,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output byte_t             rf_wdata,
    output logic              rf_re,
    input  byte_t             rf_rdata,
    output logic              out_load,
    output byte_t             out_value
);

    seq_state_e        st, st_nx;
    logic [ADDR_W-1:0] addr_q;
    logic              data_take;
    cmd_kind_e         kind;

    assign data_take = consume && !in_byte.is_cmd;
    assign kind      = decode_cmd(in_byte.value);

    assign rf_re     = data_take && (st == SQ_RD_ADDR);
    assign rf_we     = data_take && (st == SQ_WR_DATA);
    assign rf_addr   = rf_we ? addr_q : in_byte.value[ADDR_W-1:0];
    assign rf_wdata  = in_byte.value;
    assign out_load  = (st == SQ_RD_FETCH);
    assign out_value = rf_rdata;

    always_comb begin
        st_nx = st;
        if (consume && in_byte.is_cmd) begin
            // Any command restarts the sequence, whatever was in flight
            case (kind)
                CK_FETCH: st_nx = SQ_RD_ADDR;
                CK_STORE: st_nx = SQ_WR_ADDR;
                default:  st_nx = SQ_IDLE;
            endcase
        end else if (data_take) begin
            case (st)
                SQ_RD_ADDR: st_nx = SQ_RD_FETCH;
                SQ_WR_ADDR: st_nx = SQ_WR_DATA;
                default:    st_nx = SQ_IDLE;
            endcase
        end else if (st == SQ_RD_FETCH) begin
            st_nx = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            addr_q <= '0;
        end else begin
            st <= st_nx;
            if (data_take && st == SQ_WR_ADDR) addr_q <= in_byte.value[ADDR_W-1:0];
        end
    end

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && rf_re));

    assert_load_after_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        out_load |-> $past(rf_re));

    assert_unknown_idles_R7: assert property (@(posedge clk) disable iff (rst)
        (consume && in_byte.is_cmd && kind == CK_NONE) |=> (st == SQ_IDLE));

    assert_cmd_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        (consume && in_byte.is_cmd && kind == CK_FETCH) |=> (st == SQ_RD_ADDR));

    assert_idle_data_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE) |-> !(rf_we || rf_re));

endmodule

// File: rtl/ecp_host_port.sv
`timescale 1ns/1ps
module ecp_host_port
    import ecp_pkg::*;
#(
    parameter int unsigned IBF_LAT = 3,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    output logic              rf_re,
    input  logic [7:0]        rf_rdata
);

    logic     consume;
    in_byte_t in_byte;
    logic     out_load;
    byte_t    out_value;

    ecp_host_if #(.IBF_LAT(IBF_LAT)) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .consume    (consume),
        .in_byte    (in_byte),
        .out_load   (out_load),
        .out_value  (out_value)
    );

    ecp_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .consume   (consume),
        .in_byte   (in_byte),
        .rf_addr   (rf_addr),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata),
        .rf_re     (rf_re),
        .rf_rdata  (rf_rdata),
        .out_load  (out_load),
        .out_value (out_value)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> !(rf_we || rf_re));

endmodule

// File: tb/ecp_host_port_tb.sv
`timescale 1ns/1ps
module ecp_host_port_tb_top;

    localparam int unsigned LAT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = 3'd4;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] rf_addr;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic       rf_re;
    logic [7:0] rf_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [7:0] last_we_addr, last_we_data;
    logic [7:0] exp_mem [256];
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    ecp_host_port #(.IBF_LAT(LAT), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_re(rf_re),
        .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) ^ 8'h5A);
    endfunction

    // Register-file model: synchronous write, one-cycle read
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            rf_rdata <= 8'h00;
        end else begin
            if (rf_we) begin
                mem[rf_addr] <= rf_wdata;
                we_cnt <= we_cnt + 1;
                last_we_addr <= rf_addr;
                last_we_data <= rf_wdata;
            end
            if (rf_re) begin
                rf_rdata <= mem[rf_addr];
                re_cnt <= re_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<60000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 3'd4;
    endtask

    task automatic status(output logic [7:0] s);
        host_addr = 3'd4; #1; s = host_rdata;
    endtask

    task automatic rd_data(output logic [7:0] v);
        host_addr = 3'd0; host_rd = 1'b1; #1; v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_addr = 3'd4;
    endtask

    task automatic wait_ibf(input string req);
        logic [7:0] s;
        for (int n = 0; n < 500; n++) begin
            status(s);
            if (!s[1]) return;
            @(negedge clk);
        end
        check(req, 1, 0);
    endtask

    task automatic wait_obf(input string req);
        logic [7:0] s;
        for (int n = 0; n < 500; n++) begin
            status(s);
            if (s[0]) return;
            @(negedge clk);
        end
        check(req, 0, 1);
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
        wait_ibf("R4 ibf");
        wr(3'd4, 8'h80);
        wait_ibf("R4 ibf");
        wr(3'd0, a);
        wait_obf("R4 obf");
        rd_data(v);
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        wait_ibf("R5 ibf");
        wr(3'd4, 8'h81);
        wait_ibf("R5 ibf");
        wr(3'd0, a);
        wait_ibf("R5 ibf");
        wr(3'd0, d);
        wait_ibf("R5 ibf");
        exp_mem[a] = d;
    endtask

    task automatic t_reset;
        logic [7:0] s;
        status(s);
        check("R10 status after reset", s, 8'h00);
        check("R10 strobes after reset", {rf_we, rf_re}, 0);
    endtask

    task automatic t_offsets;
        logic [7:0] s;
        wr(3'd2, 8'h80);
        status(s);
        check("R1 write to offset 2 ignored", s, 8'h00);
        host_addr = 3'd1; #1;
        check("R1 read of offset 1", host_rdata, 8'h00);
        host_addr = 3'd6; #1;
        check("R1 read of offset 6", host_rdata, 8'h00);
        host_addr = 3'd4;
    endtask

    task automatic t_ibf_timing;
        logic [7:0] s;
        int n;
        int w0, r0;
        w0 = we_cnt; r0 = re_cnt;
        wr(3'd0, 8'h33);
        status(s);
        check("R2 status with input full", s, 8'h02);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            status(s);
            if (!s[1]) break;
            n++;
            @(negedge clk);
        end
        check("R3 input-full length", n, LAT);
        check("R9 idle data no write", we_cnt, w0);
        check("R9 idle data no read", re_cnt, r0);
        check("R9 idle data obf", s[0], 0);
    endtask

    task automatic t_read_timing;
        logic [7:0] s, v;
        wait_ibf("R4 ibf");
        wr(3'd4, 8'h80);
        wait_ibf("R4 ibf");
        wr(3'd0, 8'h3C);
        for (int k = 0; k < LAT; k++) @(negedge clk);
        status(s);
        check("R4 obf clear when byte consumed", s, 8'h00);
        @(negedge clk);
        status(s);
        check("R2 status with output full", s, 8'h01);
        rd_data(v);
        check("R4 read value 0x3C", v, exp_mem[8'h3C]);
        status(s);
        check("R6 obf cleared by read", s[0], 0);
        host_addr = 3'd0; #1;
        check("R6 data held after read", host_rdata, exp_mem[8'h3C]);
        host_addr = 3'd4;
    endtask

    task automatic t_reads;
        logic [7:0] v;
        ec_read(8'h00, v); check("R4 read 0x00", v, exp_mem[8'h00]);
        ec_read(8'hFF, v); check("R4 read 0xFF", v, exp_mem[8'hFF]);
        ec_read(8'h81, v); check("R4 read 0x81", v, exp_mem[8'h81]);
    endtask

    task automatic t_writes;
        logic [7:0] v;
        int w0;
        w0 = we_cnt;
        ec_write(8'h10, 8'hA5);
        check("R5 one strobe", we_cnt, w0 + 1);
        check("R5 strobe address", last_we_addr, 8'h10);
        check("R5 strobe data", last_we_data, 8'hA5);
        ec_write(8'hFF, 8'h00);
        ec_read(8'h10, v); check("R5 readback 0x10", v, 8'hA5);
        ec_read(8'hFF, v); check("R5 readback 0xFF", v, 8'h00);
    endtask

    task automatic t_unknown;
        logic [7:0] s, v;
        int w0, r0;
        w0 = we_cnt; r0 = re_cnt;
        wait_ibf("R7 ibf");
        wr(3'd4, 8'h42);
        wait_ibf("R7 ibf");
        wr(3'd0, 8'h20);
        wait_ibf("R7 ibf");
        wr(3'd0, 8'h99);
        wait_ibf("R7 ibf");
        @(negedge clk);
        status(s);
        check("R7 no write after unknown", we_cnt, w0);
        check("R7 no read after unknown", re_cnt, r0);
        check("R7 status idle", s, 8'h00);
        ec_read(8'h20, v); check("R7 target untouched", v, exp_mem[8'h20]);
    endtask

    task automatic t_abort;
        logic [7:0] s, v;
        int w0;
        w0 = we_cnt;
        wait_ibf("R8 ibf");
        wr(3'd4, 8'h81);
        wait_ibf("R8 ibf");
        wr(3'd0, 8'h44);
        ec_read(8'h55, v);
        check("R8 restarted read value", v, exp_mem[8'h55]);
        check("R8 abandoned write silent", we_cnt, w0);
        ec_read(8'h44, v);
        check("R8 abandoned target untouched", v, exp_mem[8'h44]);
        wait_ibf("R8 ibf");
        wr(3'd4, 8'h80);
        ec_write(8'h66, 8'h7E);
        status(s);
        check("R8 abandoned read leaves obf clear", s, 8'h00);
        check("R8 restarted write strobe", we_cnt, w0 + 1);
        ec_read(8'h66, v);
        check("R8 restarted write value", v, 8'h7E);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_offsets;
        t_ibf_timing;
        t_read_timing;
        t_reads;
        t_writes;
        t_unknown;
        t_abort;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule